// File: doc/BRIEF.md
# Four-Channel Pin Interrupt Flag Unit

This block watches four external pins and turns qualifying activity on each of them into a latched, per-channel flag. Each channel is configured by two bits. The trigger-type bit selects level sensitivity or edge sensitivity. The sense bit selects which level is active, or which edge counts. Every flag drives its own interrupt request output. The OR of all flags drives a single wake-up output, which lets a power controller bring the system out of a sleep state.

Software reaches the unit through a small word-addressed register port. Flags are cleared by writing ones. In level mode a clear does not take hold while the pin still sits at its active level. In that case the flag stays up, and software must clear it again after the pin has gone inactive. A flag that is never cleared keeps the channel blind to further activity.

Each channel runs a two-state machine:
- `CH_ARMED` means the flag is clear and the channel is waiting for a trigger.
- `CH_PENDING` means the flag is set.

The transition ARM (`CH_ARMED` to `CH_PENDING`) fires on a trigger. The transition CLEAR (`CH_PENDING` to `CH_ARMED`) fires on a write-one clear in a cycle with no trigger. Every other case holds the current state.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, with the pins held high, all three registers read 0, every request output is 0 and the wake-up output is 0.
- R2: The register map uses byte offsets within the block, and each register holds one bit per channel in bits [3:0], with bit n belonging to channel n. The flag register sits at 0x0, the trigger-type register at 0x8 and the sense register at 0xC. The type and sense registers read back what was written. Any other offset, and bits above [3:0], read 0.
- R3: When a channel's type bit is 0 (level), its flag sets while the synchronized pin equals the sense bit: sense 0 means active low, sense 1 means active high.
- R4: When a channel's type bit is 1 (edge), its flag sets on a falling edge if the sense bit is 0, and on a rising edge if it is 1. The opposite edge has no effect.
- R5: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves it unchanged.
- R6: In level mode, a clear written while the pin is at its active level leaves the flag set. The same clear written after the pin goes inactive clears it.
- R7: A set flag stays set until cleared, and later triggers on that channel change nothing. After a clear, the next trigger sets the flag again.
- R8: Request output n equals flag n, and the wake-up output is 1 exactly when any flag is set.
- R9: A trigger and a clear on the same channel in the same cycle leave the flag set.
- R10: A write that changes a channel's type or sense bit discards that channel's edge history for one cycle. An edge that reaches the synchronized pin in the cycle the write takes effect therefore does not set the flag.
- R11: A pin change driven between clock edges reaches the flag on the third rising clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Asynchronous external pins, one per channel |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the select |
| irq_req | output | 4 | Per-channel interrupt request |
| wake_req | output | 1 | Combined wake-up request |

## Verification
The bench builds the unit with its defaults: four channels, a 32-bit data port, a 4-bit offset and a two-stage synchronizer. With those values all four trigger kinds can run side by side on different channels from one pin pattern, and the pin-to-flag latency is a fixed three edges. The bench can therefore aim a clear or a configuration write at the exact cycle in which an edge is evaluated, which makes the same-cycle trigger-and-clear case and the edge-history masking reachable.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
package pin_irq_pkg;

    // Per-channel flag state
    typedef enum logic {
        CH_ARMED   = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_e;

    // {type, sense} taken together as one trigger kind
    typedef enum logic [1:0] {
        TRIG_LEVEL_LOW  = 2'b00,
        TRIG_LEVEL_HIGH = 2'b01,
        TRIG_EDGE_FALL  = 2'b10,
        TRIG_EDGE_RISE  = 2'b11
    } trig_kind_e;

    // Byte offsets of the registers
    localparam int unsigned OFF_FLAG  = 0;
    localparam int unsigned OFF_TYPE  = 8;
    localparam int unsigned OFF_SENSE = 12;

endpackage

// File: rtl/pin_irq_sync.sv
`timescale 1ns/1ps
module pin_irq_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pin_irq_regs.sv
`timescale 1ns/1ps
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_CH-1:0] flag_q,
    output logic [NUM_CH-1:0] type_q,
    output logic [NUM_CH-1:0] sense_q,
    output logic [NUM_CH-1:0] clr_req,
    output logic [NUM_CH-1:0] cfg_touch,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFF_FLAG);
    localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(OFF_TYPE);
    localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFF_SENSE);

    logic              wr_flag, wr_type, wr_sense;
    logic [NUM_CH-1:0] wdata_ch;

    assign wdata_ch = bus_wdata[NUM_CH-1:0];
    assign wr_flag  = bus_sel && bus_wr && (bus_addr == A_FLAG);
    assign wr_type  = bus_sel && bus_wr && (bus_addr == A_TYPE);
    assign wr_sense = bus_sel && bus_wr && (bus_addr == A_SENSE);

    // Write-one-to-clear request per channel
    assign clr_req = {NUM_CH{wr_flag}} & wdata_ch;

    // Channels whose configuration actually changes with this write
    assign cfg_touch = ({NUM_CH{wr_type}}  & (wdata_ch ^ type_q))
                     | ({NUM_CH{wr_sense}} & (wdata_ch ^ sense_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q  <= '0;
            sense_q <= '0;
        end else begin
            if (wr_type)  type_q  <= wdata_ch;
            if (wr_sense) sense_q <= wdata_ch;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_FLAG)       bus_rdata = DATA_W'(flag_q);
            else if (bus_addr == A_TYPE)  bus_rdata = DATA_W'(type_q);
            else if (bus_addr == A_SENSE) bus_rdata = DATA_W'(sense_q);
        end
    end

    // R2: a write to the type register is visible on the next cycle
    p_type_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_type |=> type_q == $past(wdata_ch));

    // R2: a write to the sense register is visible on the next cycle
    p_sense_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sense |=> sense_q == $past(wdata_ch));

endmodule

// File: rtl/pin_irq_channel.sv
`timescale 1ns/1ps
module pin_irq_channel
    import pin_irq_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic type_bit,
    input  logic sense_bit,
    input  logic clr,
    input  logic cfg_touch,
    output logic flag
);

    ch_state_e  state_q, state_d;
    trig_kind_e kind;
    logic       prev_q;
    logic       hist_ok_q;
    logic       rise_evt, fall_evt;
    logic       trigger;

    // Edge history: previous sample plus a validity bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= RST_VAL;
            hist_ok_q <= 1'b0;
        end else begin
            prev_q    <= pin_s;
            hist_ok_q <= !cfg_touch;
        end
    end

    assign rise_evt = hist_ok_q &&  pin_s && !prev_q;
    assign fall_evt = hist_ok_q && !pin_s &&  prev_q;
    assign kind     = trig_kind_e'({type_bit, sense_bit});

    always_comb begin
        unique case (kind)
            TRIG_LEVEL_LOW:  trigger = !pin_s;
            TRIG_LEVEL_HIGH: trigger =  pin_s;
            TRIG_EDGE_FALL:  trigger = fall_evt;
            TRIG_EDGE_RISE:  trigger = rise_evt;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_d;
    end

    // Transitions: ARM and CLEAR
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED:   if (trigger)           state_d = CH_PENDING;
            CH_PENDING: if (clr && !trigger)   state_d = CH_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            CH_ARMED:   flag = 1'b0;
            CH_PENDING: flag = 1'b1;
        endcase
    end

    // R7: without a clear a set flag stays set
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R6: level mode, clear while pin active leaves flag set
    p_level_clear_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!type_bit && (pin_s == sense_bit) && clr) |=> flag);

    // R9: an edge trigger beats a same-cycle clear
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (type_bit && (rise_evt || fall_evt) && (pin_s == sense_bit) && clr) |=> flag);

    // R10: an edge channel stays armed in the cycle after its configuration changed
    p_hist_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_touch && !flag) ##1 (type_bit && !flag) |=> !flag);

endmodule

// File: rtl/pin_irq_unit.sv
`timescale 1ns/1ps
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        PIN_IDLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_req,
    output logic              wake_req
);

    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] type_q, sense_q, clr_req, cfg_touch, flag_q;

    pin_irq_sync #(
        .WIDTH   (NUM_CH),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    pin_irq_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag_q    (flag_q),
        .type_q    (type_q),
        .sense_q   (sense_q),
        .clr_req   (clr_req),
        .cfg_touch (cfg_touch),
        .bus_rdata (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pin_irq_channel #(
            .RST_VAL (PIN_IDLE)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_s[c]),
            .type_bit  (type_q[c]),
            .sense_bit (sense_q[c]),
            .clr       (clr_req[c]),
            .cfg_touch (cfg_touch[c]),
            .flag      (flag_q[c])
        );
    end

    assign irq_req  = flag_q;
    assign wake_req = |flag_q;

    // R8: wake-up only rises together with a newly raised request
    p_wake_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> ($countones(irq_req) > 0 && $past(irq_req) == '0));

endmodule

// File: tb/pin_irq_unit_tb.sv
`timescale 1ns/1ps
module pin_irq_unit_tb;

    localparam int NV = 31;
    // {req[3:0], kind[1:0], addr[3:0], data[7:0], exp_irq[3:0], exp_rd[7:0]}
    // kind 0: drive pins = data[3:0]; 1: write; 2: read and compare
    localparam logic [29:0] VEC [NV] = '{
        {4'd1, 2'd2, 4'h0, 8'h00, 4'h0, 8'h00}, // R1 flags 0
        {4'd1, 2'd2, 4'h8, 8'h00, 4'h0, 8'h00}, // R1 type 0
        {4'd1, 2'd2, 4'hC, 8'h00, 4'h0, 8'h00}, // R1 sense 0
        {4'd3, 2'd0, 4'h0, 8'h0E, 4'h1, 8'h00}, // R3 level low
        {4'd6, 2'd1, 4'h0, 8'h01, 4'h1, 8'h00}, // R6 clear blocked
        {4'd2, 2'd2, 4'h0, 8'h00, 4'h1, 8'h01}, // R2 flag readback
        {4'd7, 2'd0, 4'h0, 8'h0F, 4'h1, 8'h00}, // R7 sticky
        {4'd5, 2'd1, 4'h0, 8'h00, 4'h1, 8'h00}, // R5 zero no effect
        {4'd5, 2'd1, 4'h0, 8'h01, 4'h0, 8'h00}, // R5 clear
        {4'd2, 2'd1, 4'h8, 8'h0F, 4'h0, 8'h00}, // R2 all edge
        {4'd2, 2'd2, 4'h8, 8'h00, 4'h0, 8'h0F}, // R2 type readback
        {4'd2, 2'd1, 4'hC, 8'h05, 4'h0, 8'h00}, // R2 sense write
        {4'd2, 2'd2, 4'hC, 8'h00, 4'h0, 8'h05}, // R2 sense readback
        {4'd4, 2'd0, 4'h0, 8'h0A, 4'h0, 8'h00}, // R4 wrong edge ignored
        {4'd4, 2'd0, 4'h0, 8'h00, 4'hA, 8'h00}, // R4 falling
        {4'd8, 2'd0, 4'h0, 8'h05, 4'hF, 8'h00}, // R8 rising, all set
        {4'd5, 2'd1, 4'h0, 8'h0F, 4'h0, 8'h00}, // R5 clear all
        {4'd4, 2'd0, 4'h0, 8'h00, 4'h0, 8'h00}, // R4 no trigger
        {4'd4, 2'd0, 4'h0, 8'h0F, 4'h5, 8'h00}, // R4 rising only
        {4'd4, 2'd0, 4'h0, 8'h00, 4'hF, 8'h00}, // R4 falling adds
        {4'd7, 2'd0, 4'h0, 8'h0F, 4'hF, 8'h00}, // R7 no change
        {4'd5, 2'd1, 4'h0, 8'h05, 4'hA, 8'h00}, // R5 partial clear
        {4'd7, 2'd0, 4'h0, 8'h00, 4'hA, 8'h00}, // R7 set stays
        {4'd7, 2'd0, 4'h0, 8'h0F, 4'hF, 8'h00}, // R7 rearmed
        {4'd5, 2'd1, 4'h0, 8'h0F, 4'h0, 8'h00}, // R5 clear all
        {4'd3, 2'd1, 4'h8, 8'h00, 4'h5, 8'h00}, // R3 level high
        {4'd6, 2'd1, 4'h0, 8'h05, 4'h5, 8'h00}, // R6 blocked
        {4'd7, 2'd0, 4'h0, 8'h0A, 4'h5, 8'h00}, // R7 held
        {4'd6, 2'd1, 4'h0, 8'h05, 4'h0, 8'h00}, // R6 clears when inactive
        {4'd3, 2'd1, 4'hC, 8'h0F, 4'hA, 8'h00}, // R3 high on ch1,3
        {4'd2, 2'd2, 4'h4, 8'h00, 4'hA, 8'h00}  // R2 unmapped reads 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = 4'hF;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_req;
    logic        wake_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pin_irq_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .wake_req  (wake_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        string       tag;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {28'd0, irq_req}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 wake after reset", {31'd0, wake_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v   = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[29:26], i);
            rd  = '0;
            unique case (v[25:24])
                2'd0: pin_in = v[15:12];
                2'd1: bus_write(v[23:20], {24'd0, v[19:12]});
                default: begin
                    bus_read(v[23:20], rd);
                    check({tag, " rdata"}, rd, {24'd0, v[7:0]});
                end
            endcase
            wait_cyc(5);
            check({tag, " irq"}, {28'd0, irq_req}, {28'd0, v[11:8]});
            check({tag, " R8 wake"}, {31'd0, wake_req}, {31'd0, (v[11:8] != 4'h0)});
        end

        // Prepare: all inactive, clear, all edge rising
        pin_in = 4'h0; wait_cyc(5);
        bus_write(4'h0, 32'hF);
        bus_write(4'h8, 32'hF);
        wait_cyc(3);
        check("R5 prep clear", {28'd0, irq_req}, 32'h0);

        // R11: latency of three rising edges
        @(negedge clk); pin_in = 4'h1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R11 not before third edge", {28'd0, irq_req}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R11 set on third edge", {28'd0, irq_req}, 32'h1);

        // R9: trigger and clear in the same cycle
        pin_in = 4'h0; wait_cyc(5);
        check("R9 precondition", {28'd0, irq_req}, 32'h1);
        @(negedge clk); pin_in = 4'h1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        wait_cyc(3);
        check("R9 event wins", {28'd0, irq_req}, 32'h1);
        bus_write(4'h0, 32'h1);
        wait_cyc(2);
        check("R9 later clear works", {28'd0, irq_req}, 32'h0);

        // R10: reconfiguration masks the edge evaluated in its cycle
        pin_in = 4'h0; wait_cyc(5);
        bus_write(4'hC, 32'hE);
        wait_cyc(3);
        check("R10 precondition", {28'd0, irq_req}, 32'h0);
        @(negedge clk); pin_in = 4'h1;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'hF;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        wait_cyc(5);
        check("R10 masked edge", {28'd0, irq_req}, 32'h0);
        @(negedge clk); pin_in = 4'h0; wait_cyc(5);
        @(negedge clk); pin_in = 4'h1; wait_cyc(5);
        check("R10 next edge counts", {28'd0, irq_req}, 32'h1);

        // R1: reset mid-run restores defaults
        pin_in = 4'hF; wait_cyc(5);
        check("R1 flags before reset", {28'd0, irq_req}, 32'hF);
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(3);
        check("R1 irq in reset", {28'd0, irq_req}, 32'h0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 irq after reset", {28'd0, irq_req}, 32'h0);
        bus_read(4'h8, rd);
        check("R1 type after reset", rd, 32'h0);
        bus_read(4'hC, rd);
        check("R1 sense after reset", rd, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule